// File: doc/BRIEF.md
# Host-polled trigger endpoint pair

This block carries single-event triggers in both directions between a host register bus, running on its own clock, and user logic on a separate clock that the integrator picks. A host write to the inbound trigger address turns every set bit of the written word into a pulse that lasts exactly one user-clock cycle on the matching output bit. The clock crossing is handled inside the block by a toggle request and acknowledge handshake. Writes that come while an earlier transfer is still crossing are merged into a pending word, so none is lost even when the user clock is much slower than the host clock.

In the other direction, each bit of a user event vector is sampled on the user clock. A rise between two consecutive samples sets a sticky flag, which the same kind of handshake carries back to the host domain. The host polls the flags by reading the outbound address. That read returns the flags and clears them in the same cycle. A flag that arrives in the cycle of the clearing read is kept for the next poll. Several rises of one bit between polls show up as a single set bit.

Top module: `trig_endpoint_pair`

## Requirements
- R1: For every bit set in a host write to the inbound address (default 0x40), `usr_pulse_o` shows that bit high for exactly one user-clock cycle. It is never high in two consecutive user-clock cycles.
- R2: Host writes in consecutive host cycles are all delivered. Every bit written at least once is pulsed at least once. Writes of the same bit while an earlier transfer is still crossing may merge into one pulse. A written zero bit produces no pulse.
- R3: An outbound flag bit is set when `usr_evt_i` for that bit is 0 at one rising user-clock edge and 1 at the next. A level held high sets nothing more. A high excursion that starts and ends between two rising user-clock edges sets nothing.
- R4: A set outbound flag stays set, for any length of time, until a read of the outbound address.
- R5: A read of the outbound address (default 0x41) returns the flags on `host_rdata` in that host cycle and clears them. A flag that arrives in the same host cycle as the clearing read is kept for the next poll.
- R6: A write to any address other than the inbound address produces no pulse. A read of any address other than the outbound address returns zero and leaves the flags unchanged.
- R7: Reset drives `usr_pulse_o` to zero, clears all outbound flags and drops any transfer that is pending or crossing, so no pulse appears afterwards for a write made just before reset.
- R8: Several rises of one event bit between two polls are reported as one set bit by the next poll. The poll after that returns that bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host bus clock |
| hrst_n | input | 1 | Host-domain asynchronous reset, active low |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rd | input | 1 | Host read strobe, one cycle per read |
| host_addr | input | ADDR_W (8) | Host register address |
| host_wdata | input | VEC_W (32) | Host write data, one bit per inbound trigger |
| host_rdata | output | VEC_W (32) | Outbound flags during a read of the outbound address, zero otherwise |
| uclk | input | 1 | User trigger clock |
| urst_n | input | 1 | User-domain asynchronous reset, active low |
| usr_evt_i | input | VEC_W (32) | User event levels, sampled on `uclk` |
| usr_pulse_o | output | VEC_W (32) | Inbound trigger pulses, one `uclk` cycle wide |

## Verification
The hardest case to reach from the ports is the atomic read-and-clear: a flag has to come in through the user-to-host handshake in the exact host cycle of a poll. A directed test cannot aim at that cycle, because the crossing latency depends on the phase of the two clocks. The bench therefore runs two unrelated clock periods with a long random phase. In that phase sparse random event toggles overlap frequent random polls. Every rise is time-stamped and must be reported by some poll made after it, so a flag dropped by a clearing read shows up as a missing report once the bench lets the block settle at the end.

// File: rtl/trig_ep_pkg.sv
`timescale 1ns/1ps
package trig_ep_pkg;
   localparam int unsigned MIN_SYNC_STAGES = 2;
   localparam int unsigned DEF_VEC_W       = 32;
   localparam int unsigned DEF_ADDR_W      = 8;

   function automatic logic addr_hit(input logic [DEF_ADDR_W-1:0] a,
                                     input logic [DEF_ADDR_W-1:0] b);
      return a == b;
   endfunction
endpackage

// File: rtl/trig_sync.sv
`timescale 1ns/1ps
module trig_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/trig_xfer.sv
`timescale 1ns/1ps
module trig_xfer #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         src_clk,
   input  logic         src_rst_n,
   input  logic [W-1:0] src_bits,
   input  logic         dst_clk,
   input  logic         dst_rst_n,
   output logic [W-1:0] dst_bits
);
   logic [W-1:0] pend_q, hold_q, pend_n;
   logic         req_q, ack_s, idle, launch;
   logic         req_s, seen_q;

   // source side: accumulate bits, launch a word when no transfer is open
   assign pend_n = pend_q | src_bits;
   assign idle   = (ack_s == req_q);
   assign launch = idle && (pend_n != '0);

   always_ff @(posedge src_clk or negedge src_rst_n) begin
      if (!src_rst_n) begin
         pend_q <= '0;
         hold_q <= '0;
         req_q  <= 1'b0;
      end else if (launch) begin
         hold_q <= pend_n;
         pend_q <= '0;
         req_q  <= ~req_q;
      end else begin
         pend_q <= pend_n;
      end
   end

   trig_sync #(.STAGES(STAGES)) u_ack_sync (
      .clk(src_clk), .rst_n(src_rst_n), .d(seen_q), .q(ack_s)
   );

   // destination side: a toggle of the request emits the held word once
   trig_sync #(.STAGES(STAGES)) u_req_sync (
      .clk(dst_clk), .rst_n(dst_rst_n), .d(req_q), .q(req_s)
   );

   always_ff @(posedge dst_clk or negedge dst_rst_n) begin
      if (!dst_rst_n) begin
         seen_q   <= 1'b0;
         dst_bits <= '0;
      end else begin
         seen_q   <= req_s;
         dst_bits <= (req_s != seen_q) ? hold_q : '0;
      end
   end

   // R2: the word on the crossing stays still while a transfer is open
   p_hold_stable_r2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      !idle |=> $stable(hold_q));

   // R2: incoming bits are never dropped on the source side
   p_no_drop_r2: assert property (@(posedge src_clk) disable iff (!src_rst_n)
      (src_bits != '0) |=> (($past(src_bits) & ~(pend_q | hold_q)) == '0));

   // R1: an emitted word lasts a single destination cycle
   p_single_cycle_r1: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
      (dst_bits != '0) |=> (dst_bits == '0));
endmodule

// File: rtl/trig_edge.sv
`timescale 1ns/1ps
module trig_edge #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] rise
);
   logic [W-1:0] prev_q;
   logic         armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         prev_q  <= lvl;
         armed_q <= 1'b1;
      end
   end

   assign rise = lvl & ~prev_q;

   // R3: a level that did not change between samples raises nothing
   p_level_no_retrigger_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && $stable(lvl)) |-> (rise == '0));
endmodule

// File: rtl/trig_flags.sv
`timescale 1ns/1ps
module trig_flags #(
   parameter int unsigned               W        = 32,
   parameter int unsigned               ADDR_W   = 8,
   parameter logic [ADDR_W-1:0]         OUT_ADDR = 8'h41
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      set_bits,
   output logic [W-1:0]      rdata
);
   logic [W-1:0] flags_q;
   logic         clr;

   assign clr   = rd && (addr == OUT_ADDR);
   assign rdata = clr ? flags_q : '0;

   // clearing read and fresh arrivals combine in one update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q <= '0;
      else        flags_q <= (clr ? '0 : flags_q) | set_bits;
   end

   // R4: without a poll, no set flag is lost
   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

   // R5: after a poll only the arrivals of that cycle remain
   p_keep_on_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (flags_q == $past(set_bits)));
endmodule

// File: rtl/trig_endpoint_pair.sv
`timescale 1ns/1ps
module trig_endpoint_pair
   import trig_ep_pkg::*;
#(
   parameter int unsigned       ADDR_W      = DEF_ADDR_W,
   parameter int unsigned       VEC_W       = DEF_VEC_W,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] IN_ADDR     = 8'h40,
   parameter logic [ADDR_W-1:0] OUT_ADDR    = 8'h41
) (
   input  logic              hclk,
   input  logic              hrst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [VEC_W-1:0]  host_wdata,
   output logic [VEC_W-1:0]  host_rdata,
   input  logic              uclk,
   input  logic              urst_n,
   input  logic [VEC_W-1:0]  usr_evt_i,
   output logic [VEC_W-1:0]  usr_pulse_o
);
   localparam bit ADDR_OK = (IN_ADDR != OUT_ADDR);

   if (VEC_W < 1) begin : g_bad_width
      $error("trig_endpoint_pair: VEC_W must be at least 1");
   end
   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("trig_endpoint_pair: SYNC_STAGES below minimum");
   end
   if (!ADDR_OK) begin : g_bad_addr
      $error("trig_endpoint_pair: inbound and outbound addresses collide");
   end

   logic              in_hit;
   logic [VEC_W-1:0]  in_bits;
   logic [VEC_W-1:0]  evt_rise;
   logic [VEC_W-1:0]  out_arrive;

   // inbound: host write -> user pulses
   assign in_hit  = host_wr && (host_addr == IN_ADDR);
   assign in_bits = in_hit ? host_wdata : '0;

   trig_xfer #(.W(VEC_W), .STAGES(SYNC_STAGES)) u_in_xfer (
      .src_clk  (hclk),
      .src_rst_n(hrst_n),
      .src_bits (in_bits),
      .dst_clk  (uclk),
      .dst_rst_n(urst_n),
      .dst_bits (usr_pulse_o)
   );

   // outbound: user rises -> host sticky flags
   trig_edge #(.W(VEC_W)) u_edge (
      .clk  (uclk),
      .rst_n(urst_n),
      .lvl  (usr_evt_i),
      .rise (evt_rise)
   );

   trig_xfer #(.W(VEC_W), .STAGES(SYNC_STAGES)) u_out_xfer (
      .src_clk  (uclk),
      .src_rst_n(urst_n),
      .src_bits (evt_rise),
      .dst_clk  (hclk),
      .dst_rst_n(hrst_n),
      .dst_bits (out_arrive)
   );

   trig_flags #(.W(VEC_W), .ADDR_W(ADDR_W), .OUT_ADDR(OUT_ADDR)) u_flags (
      .clk     (hclk),
      .rst_n   (hrst_n),
      .rd      (host_rd),
      .addr    (host_addr),
      .set_bits(out_arrive),
      .rdata   (host_rdata)
   );

   // R6: a write elsewhere launches nothing into the inbound crossing
   p_wr_decode_r6: assert property (@(posedge hclk) disable iff (!hrst_n)
      (host_wr && !addr_hit(host_addr, IN_ADDR)) |-> (in_bits == '0));
endmodule

// File: tb/trig_endpoint_pair_test.sv
`timescale 1ns/1ps
module trig_endpoint_pair_test;
   localparam int CLK_PERIOD  = 10;
   localparam int UCLK_PERIOD = 26;
   localparam logic [7:0] A_IN  = 8'h40;
   localparam logic [7:0] A_OUT = 8'h41;

   logic        hclk = 1'b0, uclk = 1'b0;
   logic        hrst_n = 1'b0, urst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic [31:0] usr_evt = '0;
   logic [31:0] usr_pulse;

   always #(CLK_PERIOD/2)  hclk = ~hclk;
   always #(UCLK_PERIOD/2) uclk = ~uclk;

   trig_endpoint_pair uut (
      .hclk(hclk), .hrst_n(hrst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .uclk(uclk), .urst_n(urst_n), .usr_evt_i(usr_evt), .usr_pulse_o(usr_pulse)
   );

   int checks = 0, errors = 0;

   // monitors: pulse counts, double-width pulses, event rise times
   int          cnt [32];
   int          dbl = 0;
   logic [31:0] prev_pulse = '0;
   logic [31:0] ev_prev = '0;
   logic [31:0] ever_edged = '0;
   longint      edge_t [32];

   initial for (int i = 0; i < 32; i++) begin cnt[i] = 0; edge_t[i] = -1; end

   always @(negedge uclk) begin
      if ((usr_pulse & prev_pulse) != 0) dbl++;
      for (int i = 0; i < 32; i++) if (usr_pulse[i]) cnt[i]++;
      prev_pulse = usr_pulse;
   end

   always @(posedge uclk) begin
      for (int i = 0; i < 32; i++)
         if (urst_n && usr_evt[i] && !ev_prev[i]) begin
            edge_t[i] = $time;
            ever_edged[i] = 1'b1;
         end
      ev_prev = usr_evt;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   int base [32];
   task automatic snap();
      for (int i = 0; i < 32; i++) base[i] = cnt[i];
   endtask
   // mask of bits pulsed exactly once / at least once since snap
   function automatic logic [31:0] once_mask();
      logic [31:0] m = '0;
      for (int i = 0; i < 32; i++) m[i] = (cnt[i] - base[i]) == 1;
      return m;
   endfunction
   function automatic logic [31:0] any_mask();
      logic [31:0] m = '0;
      for (int i = 0; i < 32; i++) m[i] = (cnt[i] - base[i]) >= 1;
      return m;
   endfunction

   task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
      @(negedge hclk); host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge hclk); host_wr = 1'b0;
   endtask

   task automatic hread(input logic [7:0] a, output logic [31:0] d);
      @(negedge hclk); host_rd = 1'b1; host_addr = a;
      #1 d = host_rdata;
      @(negedge hclk); host_rd = 1'b0;
   endtask

   task automatic settle();
      repeat (40) @(negedge uclk);
   endtask

   task automatic evt_set(input int b, input logic v);
      @(negedge uclk); usr_evt[b] = v;
   endtask

   task automatic do_reset();
      @(negedge hclk); hrst_n = 1'b0; urst_n = 1'b0;
      repeat (4) @(negedge hclk);
      hrst_n = 1'b1; urst_n = 1'b1;
   endtask

   logic [31:0] rd_v, exp_in;
   longint      rep_t [32];

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 32; i++) rep_t[i] = -1;
      repeat (5) @(negedge hclk);
      hrst_n = 1'b1; urst_n = 1'b1;
      repeat (3) @(negedge uclk);

      // R7: reset state
      chk("R7 pulse output after reset", usr_pulse, 32'h0);
      hread(A_OUT, rd_v);
      chk("R7 flags after reset", rd_v, 32'h0);

      // R1: single write, each set bit pulses once
      snap(); hwrite(A_IN, 32'h0000_0005); settle();
      chk("R1 single write pulse count", once_mask(), 32'h0000_0005);
      chk("R1 no other bits pulsed", any_mask(), 32'h0000_0005);

      // R2: zero data makes no pulse
      snap(); hwrite(A_IN, 32'h0); settle();
      chk("R2 zero write", any_mask(), 32'h0);

      // R6: write to a foreign address
      snap(); hwrite(8'h42, 32'hFFFF_FFFF); hwrite(A_OUT, 32'hFFFF_FFFF); settle();
      chk("R6 foreign-address write", any_mask(), 32'h0);

      // R2: back-to-back writes on consecutive host cycles
      snap();
      @(negedge hclk); host_wr = 1'b1; host_addr = A_IN; host_wdata = 32'h0000_0100;
      @(negedge hclk); host_wdata = 32'h0000_0200;
      @(negedge hclk); host_wdata = 32'h0001_0000;
      @(negedge hclk); host_wr = 1'b0;
      settle();
      chk("R2 back-to-back writes all delivered", any_mask(), 32'h0001_0300);

      // R3, R5: rise on bit 3 held high
      evt_set(3, 1'b1); settle();
      hread(A_OUT, rd_v); chk("R3 rise sets flag", rd_v, 32'h0000_0008);
      hread(A_OUT, rd_v); chk("R5 poll clears flag", rd_v, 32'h0);
      settle();
      hread(A_OUT, rd_v); chk("R3 held level no retrigger", rd_v, 32'h0);
      evt_set(3, 1'b0); settle();
      hread(A_OUT, rd_v); chk("R3 falling edge ignored", rd_v, 32'h0);

      // R4, R6: long hold, foreign read neither returns nor clears
      evt_set(7, 1'b1); evt_set(7, 1'b0);
      repeat (200) @(negedge uclk);
      hread(8'h10, rd_v); chk("R6 foreign read returns zero", rd_v, 32'h0);
      hread(A_IN, rd_v);  chk("R6 read of inbound address returns zero", rd_v, 32'h0);
      hread(A_OUT, rd_v); chk("R4 flag still set after long wait", rd_v, 32'h0000_0080);

      // R8: three rises collapse to one report
      for (int k = 0; k < 3; k++) begin
         evt_set(9, 1'b1); evt_set(9, 1'b0); @(negedge uclk);
      end
      settle();
      hread(A_OUT, rd_v); chk("R8 repeated rises reported once", rd_v, 32'h0000_0200);
      hread(A_OUT, rd_v); chk("R8 next poll clear", rd_v, 32'h0);

      // R3: excursion between two rising edges is not seen
      @(negedge uclk); #2 usr_evt[20] = 1'b1; #2 usr_evt[20] = 1'b0;
      settle();
      hread(A_OUT, rd_v); chk("R3 sub-cycle glitch ignored", rd_v, 32'h0);

      // R7: reset drops a flag and a transfer in flight
      evt_set(12, 1'b1); evt_set(12, 1'b0); settle();
      snap();
      hwrite(A_IN, 32'h0000_00F0);
      hrst_n = 1'b0; urst_n = 1'b0;
      repeat (4) @(negedge hclk);
      hrst_n = 1'b1; urst_n = 1'b1;
      settle();
      chk("R7 in-flight write dropped by reset", any_mask(), 32'h0);
      hread(A_OUT, rd_v); chk("R7 flags cleared by reset", rd_v, 32'h0);

      // random phase: mixed writes, polls and sparse event toggles
      snap(); exp_in = '0;
      fork
         begin
            for (int n = 0; n < 3000; n++) begin
               int unsigned op;
               logic [31:0] d;
               logic [7:0]  fa;
               @(negedge hclk);
               host_wr = 1'b0; host_rd = 1'b0;
               op = $urandom % 8;
               d  = $urandom & $urandom;
               fa = 8'($urandom);
               if (fa == A_IN || fa == A_OUT) fa = 8'h00;
               case (op)
                  0, 1: begin host_wr = 1'b1; host_addr = A_IN; host_wdata = d; exp_in |= d; end
                  2: begin host_wr = 1'b1; host_addr = fa; host_wdata = d; end
                  3, 4: begin
                     host_rd = 1'b1; host_addr = A_OUT;
                     #1 rd_v = host_rdata;
                     chk("R5 poll reports only bits that rose", rd_v & ~ever_edged, 32'h0);
                     for (int i = 0; i < 32; i++) if (rd_v[i]) rep_t[i] = $time;
                  end
                  5: begin
                     host_rd = 1'b1; host_addr = fa;
                     #1 chk("R6 foreign read zero (random)", host_rdata, 32'h0);
                  end
                  default: ;
               endcase
            end
            @(negedge hclk); host_wr = 1'b0; host_rd = 1'b0;
         end
         begin
            for (int n = 0; n < 1100; n++) begin
               @(negedge uclk);
               usr_evt = usr_evt ^ ($urandom & $urandom & $urandom & $urandom);
            end
         end
      join
      settle();
      hread(A_OUT, rd_v);
      for (int i = 0; i < 32; i++) if (rd_v[i]) rep_t[i] = $time;
      begin
         logic [31:0] missed = '0;
         for (int i = 0; i < 32; i++)
            if (edge_t[i] >= 0 && rep_t[i] <= edge_t[i]) missed[i] = 1'b1;
         chk("R5 every rise reported by a later poll", missed, 32'h0);
      end
      chk("R2 random writes all delivered", any_mask(), exp_in);
      chk("R1 no pulse wider than one cycle", 32'(dbl), 32'h0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
      $finish;
   end
endmodule